// File: doc/BRIEF.md
# Byte-Accessed Reload Down-Counter

This block is a 16-bit down-counter with a reload register, served over an 8-bit processor bus. Two byte addresses carry it: 0x22 holds the low byte and 0x23 the high byte. The counter and its reload register both sit behind that one address pair. A write sets the reload register and the counter at once. A read returns the live count. The reload register cannot be read back.

Each 16-bit access is made atomic by a fixed byte order. Writes go low byte first: that byte waits in a buffer until the high byte arrives. Reads go high byte first: reading the high byte also freezes the matching low byte for the read that follows.

The counter steps down once for every cycle in which the count-enable input is high. When it steps below zero it reloads from the reload register and raises a one-cycle underflow pulse. Two measurement modes also reload the counter on an edge of an external input pin, after that pin passes through a two-stage synchroniser. Period mode reacts to rising edges only. Pulse-width mode reacts to both edges.

Top module: `byte_reload_timer`

## Requirements
- R1: After reset the counter and the reload register both hold 0xFFFF, the underflow output is 0 and the captured low byte is 0xFF.
- R2: A write to address 0x22 only fills the low-byte buffer. The counter and the reload register keep their values.
- R3: A write to address 0x23 loads both the reload register and the counter with {written byte, buffered low byte}. The new value is visible on the next cycle.
- R4: A read of address 0x23 returns counter bits 15:8 combinationally and captures counter bits 7:0. A later read of 0x22 returns that captured byte, even if the counter has changed in between.
- R5: On each cycle with count enable high and a nonzero counter, the counter decreases by exactly one.
- R6: On a count-enabled cycle with the counter at 0x0000, the counter reloads from the reload register. The underflow output is 1 for exactly the next cycle, together with the reloaded value.
- R7: Reads of 0x22 and 0x23 report the counter, never the reload register. Reads of any other address return 0x00.
- R8: In measurement mode 2'b01 (period), a rising edge on the external pin reloads the counter three clock edges after the pin changes. A falling edge has no effect.
- R9: In measurement mode 2'b10 (pulse width), both rising and falling pin edges reload the counter.
- R10: In modes 2'b00 and 2'b11, pin edges do not reload the counter.
- R11: A high-byte write in the same cycle as an underflow or an edge reload wins: the counter takes the written value and no underflow pulse is raised.
- R12: An edge reload in the same cycle as a count-enabled decrement wins: the counter takes the reload value and is not decremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte address |
| busWr | input | 1 | Single-cycle write strobe |
| busRd | input | 1 | Single-cycle read strobe |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Combinational read data byte |
| countEn | input | 1 | Decrement enable for this cycle |
| measMode | input | 2 | 00 off, 01 period (rising), 10 pulse width (both), 11 off |
| extPin | input | 1 | Asynchronous external measurement input |
| underflow | output | 1 | One-cycle pulse marking an underflow reload |

## Verification
Register effects (a buffered low byte, a high-byte load, a decrement, an underflow reload) land on the first rising edge after the strobe. The bench drives inputs on falling edges and reads results one falling edge later. Read data is combinational, so it is sampled 1 ns after the read strobe and address are driven, inside the same cycle. A pin edge takes three rising edges to act: two synchroniser stages, then the reload. The collision tests therefore place the competing write or count enable in the cycle between the second and third rising edges, and every other pin test waits four falling edges before it reads.

// File: rtl/timer_pkg.sv
package timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_PULSE  = 2'b10,
    MODE_RSVD   = 2'b11
  } measMode_e;

  // Per-cycle commands from control to datapath, already prioritised.
  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic rdLow;
    logic rdHigh;
    logic decrement;
    logic edgeReload;
  } tmrStrobes_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 8'h22,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              countEn,
  input  logic [1:0]        measMode,
  input  logic              extPin,
  output tmrStrobes_t       strobes
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pinPrev;
  logic                   pinRise;
  logic                   pinFall;
  logic                   edgeHit;
  logic                   hitLow;
  logic                   hitHigh;
  measMode_e              modeSel;

  // Synchroniser chain for the asynchronous pin, then an edge history bit.
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extPin};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extPin;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) pinPrev <= 1'b0;
    else       pinPrev <= syncQ[LAST];
  end

  assign pinRise = syncQ[LAST] & ~pinPrev;
  assign pinFall = ~syncQ[LAST] & pinPrev;
  assign modeSel = measMode_e'(measMode);

  always_comb begin
    case (modeSel)
      MODE_PERIOD: edgeHit = pinRise;
      MODE_PULSE:  edgeHit = pinRise | pinFall;
      default:     edgeHit = 1'b0;
    endcase
  end

  assign hitLow  = (busAddr == LOW_ADDR);
  assign hitHigh = (busAddr == HIGH_ADDR);

  // Priority: high-byte write, then edge reload, then decrement.
  always_comb begin
    strobes            = '0;
    strobes.wrLow      = busWr & hitLow;
    strobes.wrHigh     = busWr & hitHigh;
    strobes.rdLow      = busRd & hitLow;
    strobes.rdHigh     = busRd & hitHigh;
    strobes.edgeReload = edgeHit & ~strobes.wrHigh;
    strobes.decrement  = countEn & ~strobes.wrHigh & ~strobes.edgeReload;
  end

  a_r10_idle_mode_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (measMode == 2'b00 || measMode == 2'b11) |-> !strobes.edgeReload);

  a_r8_period_rising_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.edgeReload && measMode == 2'b01) |-> (syncQ[LAST] && !pinPrev));

  a_r11_write_beats_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHigh |-> (!strobes.edgeReload && !strobes.decrement));

  a_r12_reload_beats_count: assert property (@(posedge clk) disable iff (!rstN)
    strobes.edgeReload |-> !strobes.decrement);

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] RESET_VAL = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       strobes,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              underflow
);

  localparam int CNT_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lowBuf;
  logic [BYTE_W-1:0] snapLow;
  logic [CNT_W-1:0]  latchReg;
  logic [CNT_W-1:0]  cnt;
  logic              underflowQ;
  logic              cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowBuf     <= '0;
      snapLow    <= RESET_VAL[BYTE_W-1:0];
      latchReg   <= RESET_VAL;
      cnt        <= RESET_VAL;
      underflowQ <= 1'b0;
    end else begin
      underflowQ <= 1'b0;
      if (strobes.wrLow)  lowBuf  <= wrData;
      if (strobes.rdHigh) snapLow <= cnt[BYTE_W-1:0];
      if (strobes.wrHigh) begin
        latchReg <= {wrData, lowBuf};
        cnt      <= {wrData, lowBuf};
      end else if (strobes.edgeReload) begin
        cnt <= latchReg;
      end else if (strobes.decrement) begin
        if (cntZero) begin
          cnt        <= latchReg;
          underflowQ <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (strobes.rdHigh)     rdData = cnt[CNT_W-1:BYTE_W];
    else if (strobes.rdLow) rdData = snapLow;
    else                    rdData = '0;
  end

  assign underflow = underflowQ;

  a_r2_low_write_holds: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLow |=> $stable(latchReg));

  a_r3_write_sets_both: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHigh |=> (cnt == latchReg));

  a_r4_snapshot_taken: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdHigh |=> (snapLow == $past(cnt[BYTE_W-1:0])));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decrement && !cntZero) |=> (cnt == $past(cnt) - 1'b1));

  a_r6_underflow_reloads: assert property (@(posedge clk) disable iff (!rstN)
    underflowQ |-> (cnt == latchReg));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    underflowQ |=> !underflowQ);

endmodule

// File: rtl/byte_reload_timer.sv
module byte_reload_timer
  import timer_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LOW_ADDR  = 8'h22,
  parameter logic [ADDR_W-1:0] HIGH_ADDR = 8'h23,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              countEn,
  input  logic [1:0]        measMode,
  input  logic              extPin,
  output logic              underflow
);

  tmrStrobes_t strobes;

  timer_ctrl #(
    .ADDR_W(ADDR_W),
    .LOW_ADDR(LOW_ADDR),
    .HIGH_ADDR(HIGH_ADDR),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWr(busWr),
    .busRd(busRd),
    .countEn(countEn),
    .measMode(measMode),
    .extPin(extPin),
    .strobes(strobes)
  );

  timer_datapath #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .wrData(busWdata),
    .rdData(busRdata),
    .underflow(underflow)
  );

endmodule

// File: tb/sim_byte_reload_timer.sv
`timescale 1ns/1ps
module sim_byte_reload_timer;

  localparam logic [7:0] A_LO = 8'h22;
  localparam logic [7:0] A_HI = 8'h23;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       countEn = 1'b0;
  logic [1:0] measMode = 2'b00;
  logic       extPin = 1'b0;
  logic       underflow;

  int checks = 0;
  int errors = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  byte_reload_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .countEn(countEn),
    .measMode(measMode), .extPin(extPin), .underflow(underflow)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic writeWord(input logic [15:0] v);
    busWrite(A_LO, v[7:0]);
    busWrite(A_HI, v[15:8]);
  endtask

  task automatic readWord(output logic [15:0] v);
    @(negedge clk); busRd = 1'b1; busAddr = A_HI; #1 v[15:8] = busRdata;
    @(negedge clk); busAddr = A_LO; #1 v[7:0] = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic runCount(input int n);
    @(negedge clk); countEn = 1'b1;
    repeat (n) @(negedge clk);
    countEn = 1'b0;
  endtask

  task automatic pinTo(input logic v);
    @(negedge clk); extPin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk); #1 chk("R1 underflow", {15'd0, underflow}, 16'h0000);
    readWord(rv); chk("R1 counter", rv, 16'hFFFF);
    runCount(2);
    readWord(rv); chk("R5 from reset", rv, 16'hFFFD);
    measMode = 2'b01;
    pinTo(1'b1);
    readWord(rv); chk("R1 reload register", rv, 16'hFFFF);
    pinTo(1'b0);
    measMode = 2'b00;
  endtask

  task automatic testWriteRead();
    writeWord(16'h1234);
    readWord(rv); chk("R3 load", rv, 16'h1234);
    busWrite(A_LO, 16'h00AA);
    readWord(rv); chk("R2 low only", rv, 16'h1234);
    busWrite(A_HI, 8'h56);
    readWord(rv); chk("R3 buffered low", rv, 16'h56AA);
    // snapshot survives a counter change between the two reads
    @(negedge clk); busRd = 1'b1; busAddr = A_HI; countEn = 1'b0;
    #1 rv[15:8] = busRdata;
    @(negedge clk); busRd = 1'b0; countEn = 1'b1;
    @(negedge clk); countEn = 1'b0; busRd = 1'b1; busAddr = A_LO;
    #1 rv[7:0] = busRdata;
    @(negedge clk); busRd = 1'b0;
    chk("R4 snapshot", rv, 16'h56AA);
    readWord(rv); chk("R4 fresh", rv, 16'h56A9);
    @(negedge clk); busRd = 1'b1; busAddr = 8'h40; #1 chk("R7 other addr", {8'h00, busRdata}, 16'h0000);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic testCount();
    writeWord(16'h0010);
    runCount(4);
    readWord(rv); chk("R5 decrement", rv, 16'h000C);
    chk("R7 counter not latch", rv, 16'h000C);
    writeWord(16'h0001);
    @(negedge clk); countEn = 1'b1;
    @(negedge clk); #1 chk("R6 no early pulse", {15'd0, underflow}, 16'h0000);
    @(negedge clk); countEn = 1'b0; #1 chk("R6 pulse", {15'd0, underflow}, 16'h0001);
    @(negedge clk); #1 chk("R6 one cycle", {15'd0, underflow}, 16'h0000);
    readWord(rv); chk("R6 reload", rv, 16'h0001);
  endtask

  task automatic testEdges();
    writeWord(16'h0100); runCount(5);
    measMode = 2'b01; pinTo(1'b1);
    readWord(rv); chk("R8 rising reload", rv, 16'h0100);
    runCount(3); pinTo(1'b0);
    readWord(rv); chk("R8 falling ignored", rv, 16'h00FD);
    measMode = 2'b10; pinTo(1'b1);
    readWord(rv); chk("R9 rising reload", rv, 16'h0100);
    runCount(2); pinTo(1'b0);
    readWord(rv); chk("R9 falling reload", rv, 16'h0100);
    writeWord(16'h0400); runCount(2);
    measMode = 2'b00; pinTo(1'b1);
    readWord(rv); chk("R10 mode 00", rv, 16'h03FE);
    measMode = 2'b11; pinTo(1'b0);
    readWord(rv); chk("R10 mode 11", rv, 16'h03FE);
    measMode = 2'b00;
  endtask

  task automatic testCollisions();
    // write vs underflow
    writeWord(16'h0000);
    busWrite(A_LO, 8'h77);
    @(negedge clk); countEn = 1'b1; busWr = 1'b1; busAddr = A_HI; busWdata = 8'h66;
    @(negedge clk); countEn = 1'b0; busWr = 1'b0;
    #1 chk("R11 no pulse", {15'd0, underflow}, 16'h0000);
    readWord(rv); chk("R11 write over underflow", rv, 16'h6677);
    // write vs edge reload
    writeWord(16'h0300); runCount(2);
    busWrite(A_LO, 8'hCD);
    measMode = 2'b01;
    @(negedge clk); extPin = 1'b1;
    @(negedge clk);
    @(negedge clk); busWr = 1'b1; busAddr = A_HI; busWdata = 8'hAB;
    @(negedge clk); busWr = 1'b0;
    repeat (2) @(negedge clk);
    readWord(rv); chk("R11 write over edge", rv, 16'hABCD);
    // edge reload vs decrement
    writeWord(16'h0200); runCount(2);
    measMode = 2'b10;
    @(negedge clk); extPin = 1'b0;
    @(negedge clk);
    @(negedge clk); countEn = 1'b1;
    @(negedge clk); countEn = 1'b0;
    repeat (2) @(negedge clk);
    readWord(rv); chk("R12 edge over count", rv, 16'h0200);
    measMode = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWriteRead();
    testCount();
    testEdges();
    testCollisions();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule